// File: doc/BRIEF.md
# Sampling converter start and serial readout controller

This block drives a 16-bit successive-approximation converter that has a start line, a busy flag and a serial data output. A free-running sample timer starts a conversion at a fixed rate. The controller raises the start line for a short pulse and then waits for the converter's busy flag to drop. If the flag stays high too long, the controller gives up on that conversion. After a normal conversion end, it captures the most significant bit at once. It then runs a gated serial clock to collect the remaining bits, most significant first, and presents the assembled word with a one-cycle strobe.

The sample period, start pulse width, busy blanking window, conversion time limit and serial clock half-period are all counted in system clock cycles and set by parameters. A sample trigger that arrives while a cycle is still in flight is dropped and reported with a one-cycle overrun strobe. Dropping `run_en` stops new triggers but lets a cycle in flight finish. With a 125 MHz clock, the defaults give a 4 µs sample period, a 16 ns start pulse, a 3.2 µs conversion limit and a 20.8 MHz serial clock. `BUSY_BLANK` must exceed `START_HI`, and `CONV_LIMIT` must exceed `BUSY_BLANK`.

Top module: `sar_rdout_ctrl`

## Requirements
- R1: While reset is held, `cvt_start`, `ser_clk`, `word_vld`, `overrun` and `timeout` are low and `smp_word` is zero.
- R2: With `run_en` high and the controller idle, a trigger occurs on the first cycle `run_en` is sampled high and then every `SAMPLE_PERIOD` cycles. `cvt_start` goes high right after the trigger edge. `run_en` low resets the timer.
- R3: `cvt_start` stays high for exactly `START_HI` cycles and then stays low until the next accepted trigger, so it never changes during the rest of the conversion.
- R4: No new rising edge of `cvt_start` occurs until the previous cycle has ended with `word_vld` or `timeout`.
- R5: Readout starts at the first edge where `cvt_busy` is sampled low and at least `BUSY_BLANK` cycles have passed since the `cvt_start` rising edge. `ser_clk` is never high while `cvt_busy` is high.
- R6: A readout gives exactly 16 `ser_clk` pulses. Each pulse is high for `SCK_HALF` cycles and low for `SCK_HALF` cycles. The first rising edge comes `SCK_HALF` cycles after readout starts. `ser_clk` is low at all other times.
- R7: Bit 15 of the word is `ser_din` at the readout start edge. Bits 14 down to 0 are `ser_din` at the edges where `ser_clk` falls for pulses 1 to 15 in turn, so the word is assembled most significant bit first.
- R8: `word_vld` is a one-cycle strobe at the edge of the sixteenth falling `ser_clk`. `smp_word` holds its value until the next strobe.
- R9: A trigger while a cycle is in flight raises `overrun` for one cycle. That trigger is dropped and produces no `cvt_start` edge.
- R10: If `cvt_busy` is still high `CONV_LIMIT` cycles after the `cvt_start` rising edge, `timeout` pulses for one cycle. No readout and no `word_vld` follow, and the controller returns to idle.
- R11: With the default parameters and a 360-cycle busy time, successive `word_vld` strobes come exactly 500 cycles (4 µs) apart with no overrun.
- R12: Lowering `run_en` does not abort a cycle in flight, and no new cycle starts while it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables the sample timer |
| cvt_busy | input | 1 | Converter busy flag, high during conversion |
| ser_din | input | 1 | Converter serial data |
| cvt_start | output | 1 | Conversion start line to the converter |
| ser_clk | output | 1 | Gated serial clock to the converter |
| word_vld | output | 1 | One-cycle strobe with each completed word |
| smp_word | output | DATA_W | Last completed sample word |
| overrun | output | 1 | One-cycle strobe for a dropped trigger |
| timeout | output | 1 | One-cycle strobe for a conversion that ran too long |

## Verification
The bench aims at the edges between phases:
- A busy flag that never rises tests the blanking window. A design without that window would read out one cycle after the start pulse, on a stale flag.
- A trigger forced mid-conversion by toggling `run_en` tests overrun. A design that accepted the trigger would pulse the start line again during the conversion, and the converter model reports that at once.
- A busy flag held past the limit tests the timeout path. A controller that ignored the limit would hang, and one that read out anyway would issue a word strobe.
- Words with a lone top bit, a lone bottom bit, all ones and all zeros show any bit shift or an off-by-one in the pulse count.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_CONV  = 2'd2,
    SEQ_READ  = 2'd3
  } seq_st_t;

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sar_rate_timer.sv
module sar_rate_timer #(
  parameter int PERIOD = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic tick
);

  localparam int PW = $clog2(PERIOD);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_en) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run_en && (cnt_q == '0);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_rd_pkg::*;
#(
  parameter int START_HI   = 2,
  parameter int BUSY_BLANK = 4,
  parameter int CONV_LIMIT = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  input  logic rd_last,
  output logic cvt_start,
  output logic rd_go,
  output logic ovr_evt,
  output logic tmo_evt
);

  localparam int AW = $clog2(CONV_LIMIT + 2);
  localparam logic [AW-1:0] HI_V    = AW'(START_HI);
  localparam logic [AW-1:0] BLANK_V = AW'(BUSY_BLANK);
  localparam logic [AW-1:0] LIM_V   = AW'(CONV_LIMIT);

  seq_st_t       st_q, st_d;
  logic [AW-1:0] age_q, age_d;
  logic          age_en;
  logic          cnv_q, cnv_d;
  logic          ovr_q, ovr_d;
  logic          tmo_q, tmo_d;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnv_d  = cnv_q;
    tmo_d  = 1'b0;
    rd_go  = 1'b0;
    age_en = 1'b0;
    age_d  = age_q + 1'b1;
    ovr_d  = tick && (st_q != SEQ_IDLE);
    unique case (st_q)
      SEQ_IDLE: begin
        if (tick) begin
          st_d   = SEQ_START;
          cnv_d  = 1'b1;
          age_en = 1'b1;
          age_d  = AW'(1);
        end
      end
      SEQ_START: begin
        age_en = 1'b1;
        if (age_q == HI_V) begin
          st_d  = SEQ_CONV;
          cnv_d = 1'b0;
        end
      end
      SEQ_CONV: begin
        age_en = 1'b1;
        if (!busy && (age_q >= BLANK_V)) begin
          rd_go = 1'b1;
          st_d  = SEQ_READ;
        end else if (age_q >= LIM_V) begin
          tmo_d = 1'b1;
          st_d  = SEQ_IDLE;
        end
      end
      SEQ_READ: begin
        if (rd_last) begin
          st_d = SEQ_IDLE;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      age_q <= '0;
      cnv_q <= 1'b0;
      ovr_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnv_q <= cnv_d;
      ovr_q <= ovr_d;
      tmo_q <= tmo_d;
      if (age_en) begin
        age_q <= age_d;
      end
    end
  end

  assign cvt_start = cnv_q;
  assign ovr_evt   = ovr_q;
  assign tmo_evt   = tmo_q;

endmodule

// File: rtl/sar_shift_rx.sv
module sar_shift_rx #(
  parameter int DATA_W   = 16,
  parameter int SCK_HALF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              sdo,
  output logic              sck,
  output logic              rd_last,
  output logic              vld,
  output logic [DATA_W-1:0] data
);

  localparam int HW = $clog2(SCK_HALF + 1);
  localparam int PW = $clog2(DATA_W);
  localparam logic [HW-1:0] H_LAST = HW'(SCK_HALF - 1);
  localparam logic [PW-1:0] P_LAST = PW'(DATA_W - 1);

  logic              act_q, act_d;
  logic [HW-1:0]     hc_q, hc_d;
  logic              sck_q, sck_d;
  logic [PW-1:0]     pc_q, pc_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q;
  logic              half_end, fall_now, shift_en;

  assign half_end = act_q && (hc_q == H_LAST);
  assign fall_now = half_end && sck_q;
  assign rd_last  = fall_now && (pc_q == P_LAST);
  assign shift_en = rd_go || (fall_now && !rd_last);

  // next-state logic
  always_comb begin
    act_d  = act_q;
    hc_d   = '0;
    sck_d  = 1'b0;
    pc_d   = pc_q;
    sreg_d = sreg_q;
    data_d = data_q;
    if (rd_go) begin
      act_d  = 1'b1;
      pc_d   = '0;
      sreg_d = {{(DATA_W-1){1'b0}}, sdo};
    end else if (act_q) begin
      hc_d  = half_end ? '0 : hc_q + 1'b1;
      sck_d = half_end ? ~sck_q : sck_q;
      if (fall_now) begin
        pc_d = pc_q + 1'b1;
        if (rd_last) begin
          act_d  = 1'b0;
          data_d = sreg_q;
        end else begin
          sreg_d = {sreg_q[DATA_W-2:0], sdo};
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hc_q   <= '0;
      sck_q  <= 1'b0;
      pc_q   <= '0;
      sreg_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      hc_q  <= hc_d;
      sck_q <= sck_d;
      pc_q  <= pc_d;
      vld_q <= rd_last;
      if (shift_en) begin
        sreg_q <= sreg_d;
      end
      if (rd_last) begin
        data_q <= data_d;
      end
    end
  end

  assign sck  = sck_q;
  assign vld  = vld_q;
  assign data = data_q;

endmodule

// File: rtl/sar_rdout_ctrl.sv
module sar_rdout_ctrl #(
  parameter int DATA_W        = 16,
  parameter int SAMPLE_PERIOD = 500,
  parameter int START_HI      = 2,
  parameter int BUSY_BLANK    = 4,
  parameter int CONV_LIMIT    = 400,
  parameter int SCK_HALF      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              cvt_busy,
  input  logic              ser_din,
  output logic              cvt_start,
  output logic              ser_clk,
  output logic              word_vld,
  output logic [DATA_W-1:0] smp_word,
  output logic              overrun,
  output logic              timeout
);

  logic rst_i_n;
  logic tick;
  logic rd_go;
  logic rd_last;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sar_rate_timer #(.PERIOD(SAMPLE_PERIOD)) u_timer (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .run_en (run_en),
    .tick   (tick)
  );

  sar_conv_seq #(
    .START_HI   (START_HI),
    .BUSY_BLANK (BUSY_BLANK),
    .CONV_LIMIT (CONV_LIMIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tick      (tick),
    .busy      (cvt_busy),
    .rd_last   (rd_last),
    .cvt_start (cvt_start),
    .rd_go     (rd_go),
    .ovr_evt   (overrun),
    .tmo_evt   (timeout)
  );

  sar_shift_rx #(
    .DATA_W   (DATA_W),
    .SCK_HALF (SCK_HALF)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_go   (rd_go),
    .sdo     (ser_din),
    .sck     (ser_clk),
    .rd_last (rd_last),
    .vld     (word_vld),
    .data    (smp_word)
  );

endmodule

// File: rtl/sar_rdout_ctrl_chk.sv
module sar_rdout_ctrl_chk #(
  parameter int START_HI = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cvt_start,
  input logic cvt_busy,
  input logic ser_clk,
  input logic word_vld,
  input logic overrun,
  input logic timeout
);

  localparam int CW = $clog2(START_HI + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] HI_V = CW'(START_HI);

  logic          start_q;
  logic          open_q;
  logic [CW-1:0] hi_cnt;
  logic          start_rise;

  assign start_rise = cvt_start && !start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      open_q  <= 1'b0;
      hi_cnt  <= '0;
    end else begin
      start_q <= cvt_start;
      if (start_rise) begin
        open_q <= 1'b1;
      end else if (word_vld || timeout) begin
        open_q <= 1'b0;
      end
      if (!cvt_start) begin
        hi_cnt <= '0;
      end else if (hi_cnt != CMAX) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  // R3
  start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_start |-> (hi_cnt < HI_V));

  // R4
  start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |-> !open_q);

  // R5
  sck_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !cvt_busy);

  // R6
  sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> (open_q && !cvt_start));

  // R8
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  // R9
  ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !start_rise);

  // R10
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!word_vld && !ser_clk));

endmodule

bind sar_rdout_ctrl sar_rdout_ctrl_chk #(.START_HI(START_HI)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cvt_start (cvt_start),
  .cvt_busy  (cvt_busy),
  .ser_clk   (ser_clk),
  .word_vld  (word_vld),
  .overrun   (overrun),
  .timeout   (timeout)
);

// File: tb/sar_rdout_ctrl_test.sv
`timescale 1ns/1ps
module sar_rdout_ctrl_test;

  localparam int PER   = 500;
  localparam int HI    = 2;
  localparam int BLANK = 4;
  localparam int LIMIT = 400;
  localparam int SH    = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en;
  logic        cvt_busy;
  logic        ser_din;
  logic        cvt_start;
  logic        ser_clk;
  logic        word_vld;
  logic [15:0] smp_word;
  logic        overrun;
  logic        timeout;

  always #4 clk = ~clk;

  sar_rdout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cvt_busy(cvt_busy),
    .ser_din(ser_din), .cvt_start(cvt_start), .ser_clk(ser_clk),
    .word_vld(word_vld), .smp_word(smp_word), .overrun(overrun),
    .timeout(timeout)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter model: driven on falling clock edges
  int          conv_len;
  logic [15:0] exp_q[$];
  logic [15:0] cw;
  int          widx, cv_left, cv_age, bitp;
  logic        pv_cnv, pv_sck;

  function automatic logic [15:0] pick(input int i);
    case (i % 8)
      0: pick = 16'hA5C3;
      1: pick = 16'h8000;
      2: pick = 16'h0001;
      3: pick = 16'hFFFF;
      4: pick = 16'h0000;
      5: pick = 16'h5A3C;
      6: pick = 16'h7FFE;
      default: pick = 16'h1234;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      cvt_busy = 1'b0; ser_din = 1'b0; pv_cnv = 1'b0; pv_sck = 1'b0;
      widx = 0; cv_left = 0; cv_age = 0; bitp = -1; cw = '0;
    end else begin
      if (cvt_start && !pv_cnv) begin
        chk(!cvt_busy, "R4 start during conversion", cvt_busy, 0);
        cw = pick(widx); widx++;
        exp_q.push_back(cw);
        cv_age = 0; cv_left = conv_len;
        if (conv_len == 0) begin
          ser_din = cw[15]; bitp = 15;
        end else begin
          cvt_busy = 1'b1;
        end
      end else if (cvt_busy) begin
        cv_age++;
        if (cvt_start != pv_cnv && cv_age > 5)
          chk(0, "R3 start line moved late in conversion", cv_age, 5);
        cv_left--;
        if (cv_left == 0) begin
          cvt_busy = 1'b0; ser_din = cw[15]; bitp = 15;
        end
      end
      if (ser_clk && !pv_sck) begin
        if (cvt_busy) chk(0, "R5 serial clock while busy", 1, 0);
        bitp--;
        ser_din = (bitp >= 0) ? cw[bitp] : 1'b0;
      end
      pv_cnv = cvt_start;
      pv_sck = ser_clk;
    end
  end

  // cycle-level reference model, updated on rising edges
  int          m_st, n0, m0, pcnt, cyc;
  bit          tk;
  logic        e_cnv, e_sck, e_vld, e_ovr, e_tmo;
  logic [15:0] e_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; pcnt = 0; cyc = 0; n0 = 0; m0 = 0;
      e_cnv = 0; e_sck = 0; e_vld = 0; e_ovr = 0; e_tmo = 0; e_word = '0;
    end else begin
      cyc++;
      tk = run_en && (pcnt == 0);
      pcnt = run_en ? ((pcnt == PER - 1) ? 0 : pcnt + 1) : 0;
      e_ovr = tk && (m_st != 0);
      e_tmo = 0;
      e_vld = 0;
      if (m_st == 0) begin
        if (tk) begin m_st = 1; n0 = cyc; end
      end else if (m_st == 1) begin
        if (cyc - n0 > HI) begin
          if (!cvt_busy && cyc - n0 >= BLANK) begin
            m_st = 2; m0 = cyc;
          end else if (cyc - n0 >= LIMIT) begin
            e_tmo = 1; m_st = 0;
            if (exp_q.size() > 0) void'(exp_q.pop_front());
          end
        end
      end else begin
        if (cyc - m0 == 32 * SH) begin
          e_vld = 1; m_st = 0;
          if (exp_q.size() > 0) e_word = exp_q.pop_front();
        end
      end
      e_cnv = (m_st == 1) && (cyc - n0 < HI);
      e_sck = (m_st == 2) && (((cyc - m0) / SH) % 2 == 1);
    end
  end

  // per-cycle comparison and event counters
  int  n_vld = 0, n_ovr = 0, n_tmo = 0, n_rise = 0;
  int  ncyc = 0, last_v = 0;
  bit  tp_en = 0;
  logic q_cnv = 0;

  always @(negedge clk) begin
    ncyc++;
    if (rst_n && !finished) begin
      chk(cvt_start == e_cnv, "R2 R3 start line", cvt_start, e_cnv);
      chk(ser_clk == e_sck, "R6 serial clock", ser_clk, e_sck);
      chk(word_vld == e_vld, "R8 word strobe", word_vld, e_vld);
      chk(smp_word == e_word, "R7 word value", smp_word, e_word);
      chk(overrun == e_ovr, "R9 overrun strobe", overrun, e_ovr);
      chk(timeout == e_tmo, "R10 timeout strobe", timeout, e_tmo);
      if (word_vld) begin
        if (tp_en && last_v != 0)
          chk(ncyc - last_v == PER, "R11 word spacing", ncyc - last_v, PER);
        last_v = ncyc;
        n_vld++;
      end
      if (overrun) n_ovr++;
      if (timeout) n_tmo++;
      if (cvt_start && !q_cnv) n_rise++;
      q_cnv = cvt_start;
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int v0, o0, t0, r0;
    rst_n = 1'b0; run_en = 1'b0; conv_len = 360;
    repeat (5) @(negedge clk);
    chk(!cvt_start && !ser_clk && !word_vld && !overrun && !timeout && smp_word == 0,
        "R1 reset outputs", {cvt_start, ser_clk, word_vld, overrun, timeout}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // steady sampling at the default rate
    run_en = 1'b1; tp_en = 1;
    repeat (3000) @(negedge clk);
    tp_en = 0;
    chk(n_vld >= 5, "R11 words in steady run", n_vld, 5);
    chk(n_ovr == 0, "R11 no overrun at default rate", n_ovr, 0);

    // trigger forced mid-conversion by restarting the timer
    while (!cvt_busy) @(negedge clk);
    repeat (50) @(negedge clk);
    v0 = n_vld; o0 = n_ovr;
    run_en = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
    repeat (450) @(negedge clk);
    chk(n_ovr == o0 + 1, "R9 dropped trigger flagged", n_ovr, o0 + 1);
    chk(n_vld == v0 + 1, "R12 cycle in flight completes", n_vld, v0 + 1);

    // run_en low: nothing new starts
    run_en = 1'b0;
    r0 = n_rise;
    repeat (1000) @(negedge clk);
    chk(n_rise == r0, "R12 no start while disabled", n_rise, r0);

    // busy stuck past the limit
    conv_len = 450; t0 = n_tmo; v0 = n_vld;
    run_en = 1'b1;
    repeat (420) @(negedge clk);
    run_en = 1'b0;
    chk(n_tmo == t0 + 1, "R10 timeout reported", n_tmo, t0 + 1);
    chk(n_vld == v0, "R10 no word after timeout", n_vld, v0);
    repeat (100) @(negedge clk);

    // busy never rises: blanking window decides readout start
    conv_len = 0; v0 = n_vld;
    run_en = 1'b1;
    repeat (150) @(negedge clk);
    run_en = 1'b0;
    chk(n_vld == v0 + 1, "R5 readout after blanking window", n_vld, v0 + 1);

    // resume normal sampling
    conv_len = 360;
    run_en = 1'b1;
    repeat (1000) @(negedge clk);
    run_en = 1'b0;
    repeat (600) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

endmodule